// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recent page translations and turns a 32-bit virtual address into a physical address for 4 KB pages. The upper 20 bits of the address form the virtual page number. The lower 12 bits are the page offset, which is copied straight to the result. Every slot can hold any translation, and all slots are compared in parallel. A lookup is answered one clock after it is presented.

Each slot has three status bits: valid, dirty and referenced. Any hit marks the slot referenced, and a write hit also marks it dirty. A single-cycle clear input wipes every referenced bit. When a lookup misses, the block sends a one-cycle exception pulse. An external handler then fetches the page-table entry, installs it through the refill port, and retries the access.

When a refill displaces a live slot, the block shows the old translation and its dirty and referenced bits on the eviction port for one cycle. The handler uses this to update the page table.

Top module: `xlat_buffer`

## Requirements
- R1: After a synchronous reset, every slot is invalid, every response and eviction output is 0, and the first lookup of any address misses.
- R2: A lookup presented with `lk_valid` high in one cycle is answered in the next cycle. In that cycle `rsp_valid` is 1. On a hit, `rsp_hit` is 1 and `rsp_paddr` equals the stored physical page number in bits 31:12, followed by the offset.
- R3: A lookup whose page number matches no valid slot gives `rsp_hit` = 0 and `rsp_paddr` = 0. It also raises `miss_exc` for exactly that one response cycle. A write that misses changes no slot.
- R4: A refill with `fill_valid` high writes the (page number, frame number) pair into a slot. Every later lookup of that page hits. All `NUM_ENTRIES` slots can be filled with distinct pages and hit at the same time.
- R5: A write lookup that hits sets the dirty bit of that slot. A read hit leaves the dirty bit unchanged. A refill loads the slot with dirty = 0.
- R6: Any hit sets the slot's referenced bit. A refill loads the slot with referenced = 0. A cycle with `ref_clr` high clears every referenced bit, but a hit in that same cycle still sets its own bit.
- R7: The refill target is chosen in this order: first, a valid slot whose page number equals the refill's page number; otherwise, the lowest-index invalid slot; otherwise, the lowest-index slot whose referenced bit is 0; otherwise, the slot under a rotating pointer. The pointer resets to slot 0 and advances by one, wrapping, only when it is used.
- R8: One cycle after a refill whose target slot was valid, `evict_valid` is 1 for one cycle. In that cycle `evict_vpn`, `evict_ppn`, `evict_dirty` and `evict_ref` carry the slot's contents from before the refill. A refill into an invalid slot leaves `evict_valid` at 0.
- R9: A refill for a page that is already present overwrites that slot. The old mapping is reported on the eviction port, later lookups return the new frame, and all other slots keep their mappings.
- R10: On a hit, bits 11:0 of `rsp_paddr` equal bits 11:0 of the looked-up virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | The lookup is a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| miss_exc | output | 1 | Miss exception pulse |
| rsp_paddr | output | 32 | Translated physical address (0 on miss) |
| ref_clr | input | 1 | Clear all referenced bits |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | 20 | Page number to install |
| fill_ppn | input | 20 | Frame number to install |
| evict_valid | output | 1 | A live slot was displaced |
| evict_vpn | output | 20 | Displaced page number |
| evict_ppn | output | 20 | Displaced frame number |
| evict_dirty | output | 1 | Displaced slot was written |
| evict_ref | output | 1 | Displaced slot was referenced |

## Verification
The bench works through the whole replacement order. It fills empty slots, then targets unreferenced slots after a clear, and skips over a slot that was read after that clear. A design that scanned from the wrong end, or ignored the referenced bit, would report the wrong page on the eviction port.

Once every slot is referenced, the rotating pointer must pick slot 0 and then slot 1. A pointer that never moved, or one that moved on every refill, would evict a different page. A refill of a page that is already present must report the old frame and return the new one. A design that allocated a second slot would instead evict an unrelated page and could return two frames for one page.

The dirty bit must show up only for the slot that took a store. A design that marked reads dirty, or lost the bit when the slot was replaced, would lose page-table updates.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_OFF_W = 12;
  localparam int VPN_W      = VA_W - PAGE_OFF_W;
  localparam int PPN_W      = 20;
  localparam int PA_W       = PPN_W + PAGE_OFF_W;

  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PPN_W-1:0] ppn_t;
  typedef logic [PAGE_OFF_W-1:0] off_t;
endpackage

// File: rtl/xlat_first.sv
// Lowest-index set bit of a request vector.
module xlat_first #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_cam.sv
// Parallel compare of a key against every stored page number.
module xlat_cam #(
  parameter int N = 16,
  parameter int W = 20
) (
  input  logic [N-1:0][W-1:0] tags,
  input  logic [N-1:0]        valid,
  input  logic [W-1:0]        key,
  output logic [N-1:0]        match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_victim.sv
// Refill target choice: same page, then empty, then unreferenced, then rotation.
module xlat_victim #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  same_page,
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  refd,
  input  logic [IW-1:0] rr_ptr,
  output logic [IW-1:0] victim,
  output logic          use_rr
);
  logic          sp_found, inv_found, unref_found;
  logic [IW-1:0] sp_idx, inv_idx, unref_idx;

  xlat_first #(.N(N)) u_same  (.req(same_page),     .found(sp_found),    .idx(sp_idx));
  xlat_first #(.N(N)) u_empty (.req(~valid),        .found(inv_found),   .idx(inv_idx));
  xlat_first #(.N(N)) u_unref (.req(valid & ~refd), .found(unref_found), .idx(unref_idx));

  always_comb begin
    use_rr = 1'b0;
    if (sp_found)         victim = sp_idx;
    else if (inv_found)   victim = inv_idx;
    else if (unref_found) victim = unref_idx;
    else begin
      victim = rr_ptr;
      use_rr = 1'b1;
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             miss_exc,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             ref_clr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             evict_valid,
  output logic [VPN_W-1:0] evict_vpn,
  output logic [PPN_W-1:0] evict_ppn,
  output logic             evict_dirty,
  output logic             evict_ref
);
  localparam int N = NUM_ENTRIES;

  vpn_t [N-1:0] vpn_q;
  ppn_t [N-1:0] ppn_q;
  logic [N-1:0] valid_q, dirty_q, ref_q;
  logic [N-1:0] valid_nxt, dirty_nxt, ref_nxt;
  logic [IW-1:0] rr_q;

  vpn_t lk_vpn;
  off_t lk_off;
  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_OFF_W];
  assign lk_off = lk_vaddr[PAGE_OFF_W-1:0];

  logic [N-1:0]  lk_match, fill_match;
  logic          hit_any;
  logic [IW-1:0] hit_idx;
  logic [IW-1:0] vic_idx;
  logic          vic_rr;
  logic          lk_hit;

  xlat_cam #(.N(N), .W(VPN_W)) u_cam_lk (
    .tags(vpn_q), .valid(valid_q), .key(lk_vpn), .match(lk_match));
  xlat_cam #(.N(N), .W(VPN_W)) u_cam_fill (
    .tags(vpn_q), .valid(valid_q), .key(fill_vpn), .match(fill_match));

  xlat_first #(.N(N)) u_hit_enc (.req(lk_match), .found(hit_any), .idx(hit_idx));

  xlat_victim #(.N(N)) u_victim (
    .same_page(fill_match), .valid(valid_q), .refd(ref_q),
    .rr_ptr(rr_q), .victim(vic_idx), .use_rr(vic_rr));

  assign lk_hit = lk_valid && hit_any;

  // Next-state of status vectors; a refill overrides a hit on its own slot.
  always_comb begin
    valid_nxt = valid_q;
    dirty_nxt = dirty_q;
    ref_nxt   = ref_clr ? '0 : ref_q;
    if (lk_hit) begin
      ref_nxt[hit_idx] = 1'b1;
      if (lk_write) dirty_nxt[hit_idx] = 1'b1;
    end
    if (fill_valid) begin
      valid_nxt[vic_idx] = 1'b1;
      dirty_nxt[vic_idx] = 1'b0;
      ref_nxt[vic_idx]   = 1'b0;
    end
  end

  // Translation storage: one write port addressed by the refill target.
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      vpn_q[vic_idx] <= fill_vpn;
      ppn_q[vic_idx] <= fill_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      dirty_q     <= '0;
      ref_q       <= '0;
      rr_q        <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      miss_exc    <= 1'b0;
      rsp_paddr   <= '0;
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_ppn   <= '0;
      evict_dirty <= 1'b0;
      evict_ref   <= 1'b0;
    end else begin
      valid_q   <= valid_nxt;
      dirty_q   <= dirty_nxt;
      ref_q     <= ref_nxt;
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      miss_exc  <= lk_valid && !hit_any;
      rsp_paddr <= lk_hit ? {ppn_q[hit_idx], lk_off} : '0;
      if (fill_valid && vic_rr)
        rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
      evict_valid <= fill_valid && valid_q[vic_idx];
      if (fill_valid && valid_q[vic_idx]) begin
        evict_vpn   <= vpn_q[vic_idx];
        evict_ppn   <= ppn_q[vic_idx];
        evict_dirty <= dirty_q[vic_idx];
        evict_ref   <= ref_q[vic_idx];
      end else begin
        evict_vpn   <= '0;
        evict_ppn   <= '0;
        evict_dirty <= 1'b0;
        evict_ref   <= 1'b0;
      end
    end
  end

  // R1: right after reset no slot may match a lookup.
  a_r1_empty_after_reset: assert property (@(posedge clk)
    rst |=> (valid_q == '0));

  // R2: a response appears only one cycle after a request.
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid));

  // R3: the exception pulse never accompanies a hit.
  a_r3_miss_not_hit: assert property (@(posedge clk) disable iff (rst)
    miss_exc |-> (rsp_valid && !rsp_hit));

  // R4: the refill target is live on the following cycle.
  a_r4_fill_installs: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> valid_q[$past(vic_idx)]);

  // R6: a lone clear leaves no referenced slot.
  a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
    (ref_clr && !lk_valid && !fill_valid) |=> (ref_q == '0));

  // R7: while an empty slot exists, a new page never displaces a live one.
  a_r7_empty_first: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && (fill_match == '0) && !(&valid_q)) |=> !evict_valid);

  // R8: eviction reports only follow a refill.
  a_r8_evict_after_fill: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> $past(fill_valid));

  // R9: at most one slot holds a given page.
  a_r9_unique_page: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R10: the page offset is carried through unchanged.
  a_r10_offset_passthru: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_paddr[PAGE_OFF_W-1:0] == $past(lk_vaddr[PAGE_OFF_W-1:0])));
endmodule

// File: tb/xlat_buffer_tb_top.sv
`timescale 1ns/1ps
module xlat_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        rsp_valid, rsp_hit, miss_exc;
  logic [31:0] rsp_paddr;
  logic        ref_clr = 1'b0, fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        evict_valid, evict_dirty, evict_ref;
  logic [19:0] evict_vpn, evict_ppn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlat_buffer #(.NUM_ENTRIES(16)) dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .miss_exc(miss_exc), .rsp_paddr(rsp_paddr),
    .ref_clr(ref_clr), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_ppn(evict_ppn),
    .evict_dirty(evict_dirty), .evict_ref(evict_ref));

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [19:0] vpn, input logic [11:0] off, input logic wr,
                           input logic exp_hit, input logic [19:0] exp_ppn, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_write = wr; lk_vaddr = {vpn, off};
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
    check(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    check(req, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
    check(req, "miss_exc", 64'(miss_exc), 64'(!exp_hit));
    check(req, "rsp_paddr", 64'(rsp_paddr), exp_hit ? 64'({exp_ppn, off}) : 64'd0);
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic exp_ev,
                         input logic [19:0] ev_vpn, input logic [19:0] ev_ppn,
                         input logic ev_dirty, input logic ev_ref, input string req);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    @(negedge clk);
    fill_valid = 1'b0;
    check(req, "evict_valid", 64'(evict_valid), 64'(exp_ev));
    if (exp_ev) begin
      check(req, "evict_vpn", 64'(evict_vpn), 64'(ev_vpn));
      check(req, "evict_ppn", 64'(evict_ppn), 64'(ev_ppn));
      check(req, "evict_dirty", 64'(evict_dirty), 64'(ev_dirty));
      check(req, "evict_ref", 64'(evict_ref), 64'(ev_ref));
    end
  endtask

  task automatic do_clear();
    @(negedge clk); ref_clr = 1'b1;
    @(negedge clk); ref_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "rsp_valid at reset", 64'(rsp_valid), 64'd0);
    check("R1", "miss_exc at reset", 64'(miss_exc), 64'd0);
    check("R1", "evict_valid at reset", 64'(evict_valid), 64'd0);
    do_lookup(20'h12345, 12'hABC, 1'b0, 1'b0, 20'h0, "R1");
    @(negedge clk);
    check("R3", "miss_exc single pulse", 64'(miss_exc), 64'd0);
    do_lookup(20'h00555, 12'h010, 1'b1, 1'b0, 20'h0, "R3");
  endtask

  task automatic t_fill_all();
    for (int i = 0; i < 16; i++)
      do_fill(20'h100 + 20'(i), 20'h800 + 20'(i), 1'b0, 20'h0, 20'h0, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 16; i++)
      do_lookup(20'h100 + 20'(i), 12'(i * 273 + 5), 1'b0, 1'b1, 20'h800 + 20'(i), "R4");
    do_lookup(20'h100, 12'hFFF, 1'b0, 1'b1, 20'h800, "R10");
  endtask

  task automatic t_ref_dirty();
    do_lookup(20'h103, 12'h004, 1'b1, 1'b1, 20'h803, "R5");
    do_clear();
    do_lookup(20'h105, 12'h008, 1'b0, 1'b1, 20'h805, "R6");
    do_fill(20'h200, 20'hA00, 1'b1, 20'h100, 20'h800, 1'b0, 1'b0, "R7");
    do_lookup(20'h200, 12'h000, 1'b0, 1'b1, 20'hA00, "R4");
    do_fill(20'h201, 20'hA01, 1'b1, 20'h101, 20'h801, 1'b0, 1'b0, "R5");
    do_lookup(20'h201, 12'h001, 1'b0, 1'b1, 20'hA01, "R4");
    do_fill(20'h202, 20'hA02, 1'b1, 20'h102, 20'h802, 1'b0, 1'b0, "R7");
    do_lookup(20'h202, 12'h002, 1'b0, 1'b1, 20'hA02, "R4");
    do_fill(20'h203, 20'hA03, 1'b1, 20'h103, 20'h803, 1'b1, 1'b0, "R5");
    do_lookup(20'h203, 12'h003, 1'b0, 1'b1, 20'hA03, "R4");
    do_fill(20'h2A0, 20'hAA0, 1'b1, 20'h104, 20'h804, 1'b0, 1'b0, "R7");
    do_lookup(20'h2A0, 12'h0A0, 1'b0, 1'b1, 20'hAA0, "R4");
    do_fill(20'h2A1, 20'hAA1, 1'b1, 20'h106, 20'h806, 1'b0, 1'b0, "R6");
    do_lookup(20'h2A1, 12'h0A1, 1'b0, 1'b1, 20'hAA1, "R4");
    do_lookup(20'h104, 12'h044, 1'b0, 1'b0, 20'h0, "R8");
    do_lookup(20'h105, 12'h055, 1'b0, 1'b1, 20'h805, "R6");
  endtask

  task automatic t_round_robin();
    for (int i = 7; i < 16; i++)
      do_lookup(20'h100 + 20'(i), 12'h070, 1'b0, 1'b1, 20'h800 + 20'(i), "R6");
    do_fill(20'h300, 20'hB00, 1'b1, 20'h200, 20'hA00, 1'b0, 1'b1, "R7");
    do_lookup(20'h300, 12'h300, 1'b0, 1'b1, 20'hB00, "R4");
    do_fill(20'h301, 20'hB01, 1'b1, 20'h201, 20'hA01, 1'b0, 1'b1, "R7");
    do_lookup(20'h201, 12'h001, 1'b0, 1'b0, 20'h0, "R7");
  endtask

  task automatic t_overwrite();
    do_fill(20'h108, 20'h9AB, 1'b1, 20'h108, 20'h808, 1'b0, 1'b1, "R9");
    do_lookup(20'h108, 12'h123, 1'b0, 1'b1, 20'h9AB, "R9");
    do_lookup(20'h109, 12'h456, 1'b0, 1'b1, 20'h809, "R9");
    do_lookup(20'h300, 12'h789, 1'b0, 1'b1, 20'hB00, "R9");
  endtask

  initial begin
    t_reset();
    t_fill_all();
    t_ref_dirty();
    t_round_robin();
    t_overwrite();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule